// File: doc/BRIEF.md
# Multi-Stage Trigger Capture Controller

This block takes a stream of parallel samples, one or two bytes wide, and writes each accepted sample into an external circular capture memory. Up to four chained trigger stages decide when the trigger point is reached. Each stage has a mask, a compare value and a start flag. Once the trigger fires, the block stores a programmed number of post-trigger samples and then stops. It then reports the memory address where readout should begin, so that the requested pre-trigger history comes first.

Software loads the stages through a small write port. It sets the total and post-trigger sample counts, selects the sample width and arms the block. After that it waits for the done flag. A finish command ends a capture early. A stop command aborts the capture. A clear command also wipes the stage registers. When a sample arrives while the memory cannot take it, a sticky overrun flag is raised and capture halts.

Top module: `trig_capture`

## Requirements
- R1: A sample matches the current stage when (sample AND mask) equals value, with both sides limited to the compared width.
- R2: With `wide_i`=0 (sampled at arm) only bits 7:0 of sample, mask and value are compared, and `mem_data_o[15:8]` is written as zero. With `wide_i`=1 all 16 bits are compared and stored.
- R3: Stages are walked from index 0. A match on a stage with its start flag set fires the trigger on that sample. A match on a stage without the start flag moves to the next stage for the following samples. The last stage never advances.
- R4: After an advance, a next stage whose mask and value are both zero (within the compared width) is passed at once on the same sample. If it carries the start flag, the trigger fires on that same sample.
- R5: On arm the block waits for a trigger only if some stage has its start flag set and the OR of all masks is nonzero. Otherwise it captures `read_cnt_i` samples starting at address 0, ends with done and `rd_start_o`=0, and is done at once when the count is zero.
- R6: When the trigger fires on the sample written at address T, `rd_start_o` becomes (T + 1 − P) mod DEPTH. Here P = `read_cnt_i` − `delay_cnt_i` when read exceeds delay, and 0 otherwise.
- R7: After the trigger sample, exactly `delay_cnt_i` further samples are written and then `done_o` rises. With a delay of 0, done follows the trigger sample directly.
- R8: Arm sets the write address to 0. Each write (`mem_we_o`) happens only for a sample with `smp_valid_i` and `mem_ready_i` high while capturing, and the address then advances by one modulo DEPTH.
- R9: `finish_i` while waiting or sampling raises `done_o` on the next cycle, and no further sample is written. In idle it has no effect.
- R10: `stop_i` returns the block to idle, clears `done_o` and `overrun_o`, ends all writes, and keeps the stage registers.
- R11: `clear_i` acts as stop and also zeroes every stage, so a following arm captures without waiting for a trigger.
- R12: A valid sample while capturing with `mem_ready_i` low is not written. It sets `overrun_o`, which stays set and blocks all writes until stop, clear or arm. `done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_i | input | 16 | Sample bus |
| smp_valid_i | input | 1 | Sample strobe |
| wide_i | input | 1 | 1 selects 16-bit samples, 0 selects 8-bit; taken at arm |
| stg_we_i | input | 1 | Stage register write |
| stg_sel_i | input | $clog2(NUM_STAGES) | Stage being written |
| stg_mask_i | input | 16 | Stage mask |
| stg_value_i | input | 16 | Stage compare value |
| stg_start_i | input | 1 | Stage start flag |
| read_cnt_i | input | CNT_W | Total samples to return |
| delay_cnt_i | input | CNT_W | Samples kept after the trigger |
| arm_i | input | 1 | Start a capture |
| finish_i | input | 1 | End capture now |
| stop_i | input | 1 | Abort to idle |
| clear_i | input | 1 | Abort and zero all stages |
| mem_ready_i | input | 1 | Memory can take a write this cycle |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | $clog2(DEPTH) | Memory write address |
| mem_data_o | output | 16 | Memory write data |
| done_o | output | 1 | Capture complete |
| rd_start_o | output | $clog2(DEPTH) | Address where readout begins |
| overrun_o | output | 1 | Sticky overrun error |

## Verification
The bench builds the block with DEPTH=16, four stages and 8-bit counts. At that size, captures of up to about 80 samples wrap the write address several times. They also push the readout start below address zero, so the modulo arithmetic of R6 and R8 is exercised on every long run. Four stages with random start flags and randomly all-zero stages reach both the chained advance and the same-sample pass-through. Counts up to 20 reach the zero-delay and zero-pre-trigger splits.

// File: rtl/trig_cap_pkg.sv
package trig_cap_pkg;
  localparam int SMP_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SAMPLE,
    ST_DONE,
    ST_ERR
  } cap_state_e;

  typedef struct packed {
    logic             start;
    logic [SMP_W-1:0] mask;
    logic [SMP_W-1:0] value;
  } stage_t;
endpackage

// File: rtl/trig_stage_bank.sv
module trig_stage_bank
  import trig_cap_pkg::*;
#(
  parameter int NSTG = 4,
  localparam int IW = $clog2(NSTG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             we_i,
  input  logic [IW-1:0]    sel_i,
  input  logic [SMP_W-1:0] mask_i,
  input  logic [SMP_W-1:0] value_i,
  input  logic             start_i,
  output stage_t           stg_o [NSTG]
);
  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_o[g] <= '0;
      end else if (clear_i) begin
        stg_o[g] <= '0;
      end else if (we_i && sel_i == IW'(g)) begin
        stg_o[g] <= '{start: start_i, mask: mask_i, value: value_i};
      end
    end
  end
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_cap_pkg::*;
#(
  parameter int NSTG = 4,
  localparam int IW = $clog2(NSTG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             arm_wide_i,
  input  logic             wide_i,
  input  logic             step_i,
  input  logic [SMP_W-1:0] smp_i,
  input  stage_t           stg_i [NSTG],
  output logic             wait_ok_o,
  output logic             fire_o
);
  logic [IW-1:0]    idx_q, cur;
  logic [SMP_W-1:0] cmp_m, arm_m, or_mask;
  logic             go, hit, any_start;

  assign cmp_m = wide_i ? '1 : SMP_W'(8'hff);
  assign arm_m = arm_wide_i ? '1 : SMP_W'(8'hff);

  always_comb begin
    or_mask   = '0;
    any_start = 1'b0;
    for (int k = 0; k < NSTG; k++) begin
      or_mask   = or_mask | stg_i[k].mask;
      any_start = any_start | stg_i[k].start;
    end
  end
  assign wait_ok_o = any_start && ((or_mask & arm_m) != '0);

  // walk matching stage plus any all-zero successors within one sample
  always_comb begin
    cur = idx_q;
    hit = 1'b0;
    go  = ((smp_i & stg_i[idx_q].mask & cmp_m) == (stg_i[idx_q].value & cmp_m));
    for (int k = 0; k < NSTG; k++) begin
      if (go) begin
        if (stg_i[cur].start) begin
          hit = 1'b1;
          go  = 1'b0;
        end else if (cur == IW'(NSTG - 1)) begin
          go = 1'b0;
        end else begin
          cur = cur + 1'b1;
          if (((stg_i[cur].mask | stg_i[cur].value) & cmp_m) != '0) go = 1'b0;
        end
      end
    end
  end

  assign fire_o = step_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idx_q <= '0;
    else if (arm_i)             idx_q <= '0;
    else if (step_i && !hit)    idx_q <= cur;
  end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import trig_cap_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             finish_i,
  input  logic             stop_i,
  input  logic             clear_i,
  input  logic             wide_i,
  input  logic             valid_i,
  input  logic             ready_i,
  input  logic             fire_i,
  input  logic             wait_ok_i,
  input  logic [CNT_W-1:0] read_cnt_i,
  input  logic [CNT_W-1:0] delay_cnt_i,
  output cap_state_e       state_o,
  output logic             wide_o,
  output logic             we_o,
  output logic             step_o,
  output logic [AW-1:0]    addr_o,
  output logic [AW-1:0]    rd_start_o,
  output logic             overrun_o
);
  cap_state_e       state_q;
  logic [AW-1:0]    wptr_q, rd_start_q;
  logic [CNT_W-1:0] pre_q, delay_q, remain_q;
  logic             wide_q, ovr_q, capturing, cmd, ovr_ev;

  assign capturing = (state_q == ST_WAIT) || (state_q == ST_SAMPLE);
  assign cmd       = stop_i || clear_i || arm_i || finish_i;
  assign we_o      = capturing && valid_i && ready_i && !cmd;
  assign ovr_ev    = capturing && valid_i && !ready_i && !cmd;
  assign step_o    = we_o && (state_q == ST_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      wptr_q     <= '0;
      rd_start_q <= '0;
      pre_q      <= '0;
      delay_q    <= '0;
      remain_q   <= '0;
      wide_q     <= 1'b1;
      ovr_q      <= 1'b0;
    end else if (stop_i || clear_i) begin
      state_q <= ST_IDLE;
      ovr_q   <= 1'b0;
    end else if (arm_i) begin
      wptr_q     <= '0;
      rd_start_q <= '0;
      ovr_q      <= 1'b0;
      wide_q     <= wide_i;
      delay_q    <= delay_cnt_i;
      pre_q      <= (read_cnt_i > delay_cnt_i) ? read_cnt_i - delay_cnt_i : '0;
      remain_q   <= read_cnt_i;
      if (wait_ok_i)               state_q <= ST_WAIT;
      else if (read_cnt_i == '0)   state_q <= ST_DONE;
      else                         state_q <= ST_SAMPLE;
    end else if (finish_i && capturing) begin
      state_q <= ST_DONE;
    end else if (ovr_ev) begin
      state_q <= ST_ERR;
      ovr_q   <= 1'b1;
    end else if (we_o) begin
      wptr_q <= wptr_q + 1'b1;
      if (state_q == ST_WAIT) begin
        if (fire_i) begin
          rd_start_q <= wptr_q + AW'(1) - pre_q[AW-1:0];
          remain_q   <= delay_q;
          state_q    <= (delay_q == '0) ? ST_DONE : ST_SAMPLE;
        end
      end else begin
        remain_q <= remain_q - 1'b1;
        if (remain_q == CNT_W'(1)) state_q <= ST_DONE;
      end
    end
  end

  assign state_o    = state_q;
  assign wide_o     = wide_q;
  assign addr_o     = wptr_q;
  assign rd_start_o = rd_start_q;
  assign overrun_o  = ovr_q;
endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import trig_cap_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int DEPTH      = 1024,
  parameter int CNT_W      = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(NUM_STAGES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      smp_i,
  input  logic             smp_valid_i,
  input  logic             wide_i,
  input  logic             stg_we_i,
  input  logic [SW-1:0]    stg_sel_i,
  input  logic [15:0]      stg_mask_i,
  input  logic [15:0]      stg_value_i,
  input  logic             stg_start_i,
  input  logic [CNT_W-1:0] read_cnt_i,
  input  logic [CNT_W-1:0] delay_cnt_i,
  input  logic             arm_i,
  input  logic             finish_i,
  input  logic             stop_i,
  input  logic             clear_i,
  input  logic             mem_ready_i,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [15:0]      mem_data_o,
  output logic             done_o,
  output logic [AW-1:0]    rd_start_o,
  output logic             overrun_o
);
  stage_t     stg [NUM_STAGES];
  cap_state_e state;
  logic       wide_q, step, fire, wait_ok;

  trig_stage_bank #(.NSTG(NUM_STAGES)) bank_i (
    .clk_i, .rst_ni, .clear_i,
    .we_i(stg_we_i), .sel_i(stg_sel_i), .mask_i(stg_mask_i),
    .value_i(stg_value_i), .start_i(stg_start_i), .stg_o(stg)
  );

  trig_seq #(.NSTG(NUM_STAGES)) seq_i (
    .clk_i, .rst_ni, .arm_i, .arm_wide_i(wide_i), .wide_i(wide_q),
    .step_i(step), .smp_i, .stg_i(stg), .wait_ok_o(wait_ok), .fire_o(fire)
  );

  cap_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) ctrl_i (
    .clk_i, .rst_ni, .arm_i, .finish_i, .stop_i, .clear_i, .wide_i,
    .valid_i(smp_valid_i), .ready_i(mem_ready_i), .fire_i(fire),
    .wait_ok_i(wait_ok), .read_cnt_i, .delay_cnt_i,
    .state_o(state), .wide_o(wide_q), .we_o(mem_we_o), .step_o(step),
    .addr_o(mem_addr_o), .rd_start_o, .overrun_o
  );

  assign mem_data_o = wide_q ? smp_i : {8'h00, smp_i[7:0]};
  assign done_o     = (state == ST_DONE);
endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk
  import trig_cap_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input cap_state_e    state_i,
  input logic          mem_we_i,
  input logic [AW-1:0] addr_i,
  input logic          done_i,
  input logic          overrun_i,
  input logic          arm_i,
  input logic          stop_i,
  input logic          clear_i,
  input logic          finish_i,
  input logic          valid_i,
  input logic          ready_i
);
  AST_WE_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> (valid_i && ready_i)); // R8
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && !arm_i) |=> addr_i == AW'($past(addr_i) + 1'b1)); // R8
  AST_ARM_ADDR0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !stop_i && !clear_i) |=> addr_i == '0); // R8
  AST_NO_WRITE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !mem_we_i); // R9
  AST_FINISH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish_i && (state_i == ST_WAIT || state_i == ST_SAMPLE) && !arm_i && !stop_i && !clear_i)
      |=> done_i); // R9
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i || clear_i) |=> (!done_i && !overrun_i && !mem_we_i)); // R10
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_i && !stop_i && !clear_i && !arm_i) |=> overrun_i); // R12
  AST_OVR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_i |-> (!mem_we_i && !done_i)); // R12
endmodule

bind trig_capture trig_capture_chk #(.AW(AW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state), .mem_we_i(mem_we_o),
  .addr_i(mem_addr_o), .done_i(done_o), .overrun_i(overrun_o),
  .arm_i(arm_i), .stop_i(stop_i), .clear_i(clear_i), .finish_i(finish_i),
  .valid_i(smp_valid_i), .ready_i(mem_ready_i)
);

// File: tb/trig_capture_tb_top.sv
module trig_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSTG  = 4;
  localparam int DEPTH = 16;
  localparam int CNT_W = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int RUN_N = 80;

  logic clk = 0, rst_n = 0;
  logic [15:0] smp_i = '0;
  logic smp_valid_i = 0, wide_i = 1, stg_we_i = 0, stg_start_i = 0;
  logic [1:0] stg_sel_i = '0;
  logic [15:0] stg_mask_i = '0, stg_value_i = '0;
  logic [CNT_W-1:0] read_cnt_i = '0, delay_cnt_i = '0;
  logic arm_i = 0, finish_i = 0, stop_i = 0, clear_i = 0, mem_ready_i = 1;
  logic mem_we_o, done_o, overrun_o;
  logic [AW-1:0] mem_addr_o, rd_start_o;
  logic [15:0] mem_data_o;

  int checks = 0, fails = 0;
  bit [15:0] m_mask [NSTG];
  bit [15:0] m_val  [NSTG];
  bit        m_st   [NSTG];
  bit [15:0] smp_a  [RUN_N];
  int wcnt, werr;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_capture #(.NUM_STAGES(NSTG), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_i, .smp_valid_i, .wide_i,
    .stg_we_i, .stg_sel_i, .stg_mask_i, .stg_value_i, .stg_start_i,
    .read_cnt_i, .delay_cnt_i, .arm_i, .finish_i, .stop_i, .clear_i,
    .mem_ready_i, .mem_we_o, .mem_addr_o, .mem_data_o, .done_o,
    .rd_start_o, .overrun_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_stage(input int k, input bit [15:0] m, input bit [15:0] v, input bit s);
    @(negedge clk);
    stg_we_i = 1; stg_sel_i = 2'(k); stg_mask_i = m; stg_value_i = v; stg_start_i = s;
    @(negedge clk);
    stg_we_i = 0;
    m_mask[k] = m; m_val[k] = v; m_st[k] = s;
  endtask

  // 0 arm, 1 finish, 2 stop, 3 clear
  task automatic cmd(input int c);
    @(negedge clk);
    case (c)
      0: arm_i = 1;
      1: finish_i = 1;
      2: stop_i = 1;
      default: clear_i = 1;
    endcase
    @(negedge clk);
    arm_i = 0; finish_i = 0; stop_i = 0; clear_i = 0;
    if (c == 3) for (int k = 0; k < NSTG; k++) begin m_mask[k] = 0; m_val[k] = 0; m_st[k] = 0; end
  endtask

  task automatic run(input int n, input bit wide);
    wcnt = 0; werr = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (done_o || overrun_o) begin smp_valid_i = 0; break; end
      smp_i = smp_a[i]; smp_valid_i = 1;
      #1;
      if (mem_we_o) begin
        if (mem_addr_o != AW'(wcnt)) werr++;
        if (mem_data_o != (wide ? smp_a[i] : {8'h00, smp_a[i][7:0]})) werr++;
        wcnt++;
      end
    end
    if (smp_valid_i) begin @(negedge clk); smp_valid_i = 0; end
  endtask

  function automatic bit ref_wait_ok(input bit wide);
    bit [15:0] cm = wide ? 16'hffff : 16'h00ff;
    bit [15:0] om = 0; bit st = 0;
    for (int k = 0; k < NSTG; k++) begin om |= m_mask[k]; st |= m_st[k]; end
    return st && ((om & cm) != 0);
  endfunction

  function automatic int ref_trig(input int n, input bit wide);
    bit [15:0] cm = wide ? 16'hffff : 16'h00ff;
    int idx = 0;
    for (int i = 0; i < n; i++) begin
      if ((smp_a[i] & m_mask[idx] & cm) == (m_val[idx] & cm)) begin
        for (int g = 0; g < NSTG; g++) begin
          if (m_st[idx]) return i;
          if (idx == NSTG-1) break;
          idx++;
          if (((m_mask[idx] | m_val[idx]) & cm) != 0) break;
        end
      end
    end
    return -1;
  endfunction

  // arm, run, compare done / write count / readout start / addr+data
  task automatic scenario(input string req, input bit wide, input int rd, input int dl);
    int trig, exp_w, exp_rs, pre;
    bit wt, fin;
    wide_i = wide; read_cnt_i = CNT_W'(rd); delay_cnt_i = CNT_W'(dl);
    wt = ref_wait_ok(wide);
    cmd(0);
    run(RUN_N, wide);
    pre = (rd > dl) ? rd - dl : 0;
    fin = 1;
    if (wt) begin
      trig = ref_trig(RUN_N, wide);
      if (trig < 0 || trig + 1 + dl > RUN_N) begin fin = 0; exp_w = RUN_N; exp_rs = 0; end
      else begin exp_w = trig + 1 + dl; exp_rs = (trig + 1 - pre) & (DEPTH-1); end
    end else begin
      exp_w = rd; exp_rs = 0;
    end
    if (!fin) begin
      chk(done_o == 0, {req, " waiting"}, done_o, 0);
      cmd(1);
      chk(done_o == 1, "R9 finish", done_o, 1);
    end else begin
      chk(done_o == 1, {req, " done"}, done_o, 1);
      chk(rd_start_o == AW'(exp_rs), {req, " rd_start R6"}, rd_start_o, exp_rs);
    end
    chk(wcnt == exp_w, {req, " writes R7"}, wcnt, exp_w);
    chk(werr == 0, {req, " addr/data R8"}, werr, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int k = 0; k < NSTG; k++) begin m_mask[k] = 0; m_val[k] = 0; m_st[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(done_o == 0 && overrun_o == 0, "reset state", {done_o, overrun_o}, 0);
    chk(mem_addr_o == 0 && mem_we_o == 0, "reset R8", mem_addr_o, 0);

    // R5 immediate capture after cleared stages
    cmd(3);
    for (int i = 0; i < RUN_N; i++) smp_a[i] = 16'(i * 7);
    scenario("R5 immediate", 1, 5, 2);
    cmd(2);

    // R1 R3 chained stages
    set_stage(0, 16'h00ff, 16'h000a, 0);
    set_stage(1, 16'h00ff, 16'h000b, 1);
    for (int i = 0; i < RUN_N; i++) smp_a[i] = 16'h0000;
    smp_a[0] = 16'h000b; smp_a[1] = 16'h000a; smp_a[3] = 16'h000b;
    scenario("R3 chain", 1, 4, 2);
    chk(rd_start_o == 2, "R1 R3 trigger at 3", rd_start_o, 2);

    // R4 zero stage passthrough with start
    cmd(3);
    set_stage(0, 16'h00ff, 16'h0011, 0);
    set_stage(2, 16'h0000, 16'h0000, 1);
    for (int i = 0; i < RUN_N; i++) smp_a[i] = 16'h0000;
    smp_a[2] = 16'h0011;
    scenario("R4 passthrough", 1, 3, 1);
    chk(rd_start_o == 1, "R4 same-sample fire", rd_start_o, 1);

    // R2 8-bit compare ignores high byte
    cmd(3);
    set_stage(0, 16'hffff, 16'h0011, 1);
    for (int i = 0; i < RUN_N; i++) smp_a[i] = 16'h0000;
    smp_a[0] = 16'h1100; smp_a[1] = 16'h5511;
    scenario("R2 narrow", 0, 2, 1);
    chk(rd_start_o == 1, "R2 trigger on low byte", rd_start_o, 1);

    // R7 zero delay; R6 wrap
    cmd(3);
    set_stage(0, 16'h000f, 16'h0003, 1);
    for (int i = 0; i < RUN_N; i++) smp_a[i] = 16'h0000;
    smp_a[2] = 16'h0003;
    scenario("R7 zero delay", 1, 4, 0);
    chk(rd_start_o == 15, "R6 negative wrap", rd_start_o, 15);
    for (int i = 0; i < RUN_N; i++) smp_a[i] = 16'h0000;
    smp_a[13] = 16'h0003;
    scenario("R6 wrap", 1, 10, 6);

    // R9 finish in wait, then writes blocked; finish in idle ignored
    for (int i = 0; i < RUN_N; i++) smp_a[i] = 16'h0000;
    wide_i = 1; read_cnt_i = 4; delay_cnt_i = 2;
    cmd(0);
    run(3, 1);
    chk(wcnt == 3 && done_o == 0, "R9 waiting", wcnt, 3);
    cmd(1);
    chk(done_o == 1, "R9 finish done", done_o, 1);
    run(3, 1);
    chk(wcnt == 0, "R9 no write after finish", wcnt, 0);
    cmd(2);
    cmd(1);
    chk(done_o == 0, "R9 finish in idle", done_o, 0);

    // R10 stop during wait keeps stages
    cmd(0);
    run(2, 1);
    cmd(2);
    smp_a[0] = 16'h0003;
    run(2, 1);
    chk(wcnt == 0 && done_o == 0, "R10 idle after stop", wcnt, 0);
    for (int i = 0; i < RUN_N; i++) smp_a[i] = 16'h0000;
    smp_a[4] = 16'h0003;
    scenario("R10 stages kept", 1, 2, 1);
    chk(rd_start_o == 4, "R10 trigger from kept stage", rd_start_o, 4);

    // R11 clear wipes stages
    cmd(3);
    scenario("R11 cleared", 1, 6, 6);

    // R12 overrun
    cmd(3);
    wide_i = 1; read_cnt_i = 10; delay_cnt_i = 0;
    cmd(0);
    @(negedge clk);
    smp_valid_i = 1; mem_ready_i = 0; smp_i = 16'h1234;
    #1 chk(mem_we_o == 0, "R12 no write when busy", mem_we_o, 0);
    @(negedge clk);
    mem_ready_i = 1;
    chk(overrun_o == 1 && done_o == 0, "R12 overrun set", overrun_o, 1);
    smp_valid_i = 0;
    for (int i = 0; i < RUN_N; i++) smp_a[i] = 16'h0001;
    run(4, 1);
    chk(wcnt == 0 && overrun_o == 1, "R12 sticky blocks writes", wcnt, 0);
    cmd(2);
    chk(overrun_o == 0, "R10 stop clears overrun", overrun_o, 1'b0);

    // random
    for (int t = 0; t < 30; t++) begin
      bit wd;
      cmd(3);
      for (int k = 0; k < NSTG; k++) begin
        bit [15:0] m = 16'($urandom) & 16'h0207;
        bit [15:0] v = 16'($urandom) & m;
        if ($urandom_range(3) == 0) begin m = 0; v = 0; end
        set_stage(k, m, v, (k == NSTG-1) ? 1'b1 : ($urandom_range(9) < 3));
      end
      for (int i = 0; i < RUN_N; i++) smp_a[i] = 16'($urandom);
      wd = 1'($urandom);
      scenario("R1 R3 R4 R6 R7 random", wd, $urandom_range(20), $urandom_range(20));
      cmd(2);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule